// File: doc/BRIEF.md
# Ethernet transmit statistics counters

This block keeps per-frame transmit statistics for an Ethernet MAC. It watches the event strobes from the transmit engine: frame start, carrier sense seen at the first attempt, collision with the bit position where it happened, underrun and frame done. During a frame it gathers these events into per-frame flags. When the frame-done strobe arrives it sorts the frame into classes and updates three saturating counters: deferred frames, frames with a collision, and frames with a late collision.

A small controller with two states tracks the frame. In `IDLE` the block waits. The transition `IDLE -> ACTIVE` happens on `frm_start`: the flags are loaded from that cycle's events, and carrier sense is captured only here. In `ACTIVE`, collision and underrun events are ORed into the flags. The transition `ACTIVE -> IDLE` happens on `frm_done`: the frame is classified, using the flags together with any event in that same cycle, the counters are updated and the flags are cleared. A `frm_start` seen in `ACTIVE` is ignored, and so is a `frm_done` seen in `IDLE`.

Software reads and writes the counters through a simple register bus. Reads are combinational and writes are single-cycle. The deferred counter is at offset 0x58, the late-collision counter at 0x5C and the collision counter at 0x60.

Top module: `eth_tx_stats`

## Requirements
- R1: After reset, all three registers read 0.
- R2: At frame done, the deferred counter (16 bits, register bits 15:0, offset 0x58) increments by one if carrier sense was high in the `frm_start` cycle and the frame had neither a collision nor an underrun.
- R3: A frame with any collision is not counted as deferred, even if carrier sense was high at the start.
- R4: A frame with an underrun is not counted as deferred.
- R5: A collision counts as late when `col_pos` is 512 or more; at 511 it is not late.
- R6: At frame done, the collision counter (16 bits, offset 0x60) increments by one if the frame had at least one collision. The late-collision counter (8 bits, bits 7:0, offset 0x5C) increments by one if the frame had a late collision. A late collision therefore updates both counters.
- R7: Counters change only on a `frm_done` that follows a `frm_start`. Events and `frm_done` strobes seen outside a frame have no effect.
- R8: Each counter saturates at its all-ones value and does not wrap.
- R9: A register write loads the written value into the counter field. A write in the same cycle as an increment wins, and the increment is lost.
- R10: Register bits above a counter's width read 0, and writes to them are ignored. Any address other than the three offsets reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_start | input | 1 | First transmission attempt of a frame begins |
| crs_first | input | 1 | Carrier sense high at the first attempt (sampled with frm_start) |
| col | input | 1 | Collision strobe |
| col_pos | input | 16 | Bit time since transmit start at which the collision happened |
| urun | input | 1 | Transmit underrun strobe |
| frm_done | input | 1 | Frame finished |
| reg_addr | input | 8 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |

## Verification
On every cycle, the assertions check the counter arithmetic: hold when idle, step by one, saturate, and let a write win over an increment. They also check that the deferred class never coexists with a collision or an underrun, that a late collision always counts as a collision, that frame-done outside a frame never causes an update, and that the unused high read bits stay zero. Only the bench scenarios can show that a given event pattern lands in the right counters. This covers the 511/512 boundary, carrier sense counted only at the start of a frame, and strobes between frames leaving every register unchanged.

// File: rtl/eth_txs_pkg.sv
package eth_txs_pkg;
    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_ACTIVE = 1'b1
    } txs_state_t;

    localparam int NUM_CNT = 3;
    localparam int IDX_DEF  = 0;
    localparam int IDX_COL  = 1;
    localparam int IDX_LATE = 2;

    localparam logic [7:0] OFS_DEF  = 8'h58;
    localparam logic [7:0] OFS_LATE = 8'h5C;
    localparam logic [7:0] OFS_COL  = 8'h60;

    function automatic logic [7:0] cnt_ofs(input int idx);
        case (idx)
            IDX_DEF: cnt_ofs = OFS_DEF;
            IDX_COL: cnt_ofs = OFS_COL;
            default: cnt_ofs = OFS_LATE;
        endcase
    endfunction
endpackage

// File: rtl/eth_txs_frame_fsm.sv
module eth_txs_frame_fsm
    import eth_txs_pkg::*;
#(
    parameter int POS_W     = 16,
    parameter int SLOT_BITS = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frm_start,
    input  logic             crs_first,
    input  logic             col,
    input  logic [POS_W-1:0] col_pos,
    input  logic             urun,
    input  logic             frm_done,
    output logic             upd_def,
    output logic             upd_col,
    output logic             upd_late
);
    localparam logic [POS_W-1:0] SLOT_LIM = POS_W'(SLOT_BITS);

    txs_state_t state_q;
    logic def_q, col_q, late_q, urun_q;
    logic late_hit;
    logic any_col, any_late, any_urun, closing;

    assign late_hit = col && (col_pos >= SLOT_LIM);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:   if (frm_start) state_q <= ST_ACTIVE;
                ST_ACTIVE: if (frm_done)  state_q <= ST_IDLE;
                default:   state_q <= ST_IDLE;
            endcase
        end
    end

    // per-frame flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            def_q  <= 1'b0;
            col_q  <= 1'b0;
            late_q <= 1'b0;
            urun_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (frm_start) begin
                        def_q  <= crs_first;
                        col_q  <= col;
                        late_q <= late_hit;
                        urun_q <= urun;
                    end
                end
                ST_ACTIVE: begin
                    if (frm_done) begin
                        def_q  <= 1'b0;
                        col_q  <= 1'b0;
                        late_q <= 1'b0;
                        urun_q <= 1'b0;
                    end else begin
                        col_q  <= col_q  | col;
                        late_q <= late_q | late_hit;
                        urun_q <= urun_q | urun;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        closing  = 1'b0;
        any_col  = col_q  | col;
        any_late = late_q | late_hit;
        any_urun = urun_q | urun;
        unique case (state_q)
            ST_IDLE:   closing = 1'b0;
            ST_ACTIVE: closing = frm_done;
            default:   closing = 1'b0;
        endcase
        upd_def  = closing & def_q & ~any_col & ~any_urun;
        upd_col  = closing & any_col;
        upd_late = closing & any_late;
    end

    // R3 R4: deferred class never coexists with a collision or underrun
    a_r3_def_excl: assert property (@(posedge clk) disable iff (!rst_n)
        upd_def |-> !(col || col_q || urun || urun_q));
    // R6: a late collision is always also a collision
    a_r6_late_is_col: assert property (@(posedge clk) disable iff (!rst_n)
        upd_late |-> upd_col);
    // R7: no update outside a frame
    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !(upd_def || upd_col || upd_late));
    // R7: frame done returns to idle
    a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACTIVE && frm_done) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/eth_txs_counter.sv
module eth_txs_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (wr) begin
            count <= wdata;
        end else if (inc && count != CNT_MAX) begin
            count <= count + 1'b1;
        end
    end

    // R9: write loads value, winning over increment
    a_r9_write_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (count == $past(wdata)));
    // R8: saturated counter stays saturated
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr && count == CNT_MAX) |=> (count == CNT_MAX));
    // R2 R6: single step increment
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !wr && count != CNT_MAX) |=> (count == $past(count) + 1'b1));
    // R7: no event, no change
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !wr) |=> $stable(count));
endmodule

// File: rtl/eth_tx_stats.sv
module eth_tx_stats
    import eth_txs_pkg::*;
#(
    parameter int POS_W     = 16,
    parameter int SLOT_BITS = 512,
    parameter int DEF_W     = 16,
    parameter int COL_W     = 16,
    parameter int LATE_W    = 8,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_start,
    input  logic              crs_first,
    input  logic              col,
    input  logic [POS_W-1:0]  col_pos,
    input  logic              urun,
    input  logic              frm_done,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata
);
    logic [NUM_CNT-1:0] inc_v;
    logic [NUM_CNT-1:0] hit_v;
    logic [DATA_W-1:0]  cnt_ext [NUM_CNT];

    eth_txs_frame_fsm #(
        .POS_W     (POS_W),
        .SLOT_BITS (SLOT_BITS)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .frm_start (frm_start),
        .crs_first (crs_first),
        .col       (col),
        .col_pos   (col_pos),
        .urun      (urun),
        .frm_done  (frm_done),
        .upd_def   (inc_v[IDX_DEF]),
        .upd_col   (inc_v[IDX_COL]),
        .upd_late  (inc_v[IDX_LATE])
    );

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        localparam int CW = (g == IDX_DEF) ? DEF_W :
                            (g == IDX_COL) ? COL_W : LATE_W;
        logic [CW-1:0] cval;

        assign hit_v[g] = (reg_addr == ADDR_W'(cnt_ofs(g)));

        eth_txs_counter #(.W(CW)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (inc_v[g]),
            .wr    (reg_wr && hit_v[g]),
            .wdata (reg_wdata[CW-1:0]),
            .count (cval)
        );

        assign cnt_ext[g] = DATA_W'(cval);
    end

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_CNT; i++) begin
            if (hit_v[i]) reg_rdata = cnt_ext[i];
        end
    end

    // R10: high bits of the late register read zero
    a_r10_late_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
        hit_v[IDX_LATE] |-> (reg_rdata[DATA_W-1:LATE_W] == '0));
    // R10: high bits of the deferred register read zero
    a_r10_def_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
        hit_v[IDX_DEF] |-> (reg_rdata[DATA_W-1:DEF_W] == '0));
    // R10: unmapped offsets read zero
    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_v == '0) |-> (reg_rdata == '0));
endmodule

// File: tb/eth_tx_stats_tb.sv
module eth_tx_stats_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frm_start = 0, crs_first = 0, col = 0, urun = 0, frm_done = 0;
    logic [15:0] col_pos = '0;
    logic [7:0]  reg_addr = '0;
    logic        reg_wr = 0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    eth_tx_stats dut_i (
        .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .crs_first(crs_first),
        .col(col), .col_pos(col_pos), .urun(urun), .frm_done(frm_done),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    // {crs, col, urun, pos[15:0], exp_def, exp_col, exp_late}
    localparam int NV = 8;
    localparam logic [21:0] VEC [NV] = '{
        {1'b1, 1'b0, 1'b0, 16'd0,    1'b1, 1'b0, 1'b0}, // R2 deferred
        {1'b0, 1'b0, 1'b0, 16'd0,    1'b0, 1'b0, 1'b0}, // R2 plain frame
        {1'b1, 1'b1, 1'b0, 16'd100,  1'b0, 1'b1, 1'b0}, // R3 collision blocks deferred
        {1'b1, 1'b0, 1'b1, 16'd0,    1'b0, 1'b0, 1'b0}, // R4 underrun blocks deferred
        {1'b0, 1'b1, 1'b0, 16'd511,  1'b0, 1'b1, 1'b0}, // R5 not late at 511
        {1'b0, 1'b1, 1'b0, 16'd512,  1'b0, 1'b1, 1'b1}, // R5 R6 late at 512
        {1'b1, 1'b1, 1'b0, 16'd2000, 1'b0, 1'b1, 1'b1}, // R6 late, crs
        {1'b1, 1'b0, 1'b0, 16'd0,    1'b1, 1'b0, 1'b0}  // R2 deferred again
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic frame(input logic c_crs, input logic c_col, input logic [15:0] pos,
                         input logic c_urun);
        @(negedge clk);
        frm_start = 1; crs_first = c_crs;
        @(negedge clk);
        frm_start = 0; crs_first = 0; col = c_col; col_pos = pos; urun = c_urun;
        @(negedge clk);
        col = 0; urun = 0; col_pos = '0; frm_done = 1;
        @(negedge clk);
        frm_done = 0;
    endtask

    task automatic check_all(input string req, input int ed, input int ec, input int el);
        logic [31:0] d;
        rd(8'h58, d); check({req, " deferred"}, d, ed);
        rd(8'h60, d); check({req, " collision"}, d, ec);
        rd(8'h5C, d); check({req, " late"}, d, el);
    endtask

    initial begin
        logic [31:0] d;
        int ed = 0, ec = 0, el = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        check_all("R1", 0, 0, 0);

        for (int i = 0; i < NV; i++) begin
            frame(VEC[i][21], VEC[i][20], VEC[i][18:3], VEC[i][19]);
            ed += int'(VEC[i][2]); ec += int'(VEC[i][1]); el += int'(VEC[i][0]);
            check_all($sformatf("R2/R6 vector %0d", i), ed, ec, el);
        end

        // R7: strobes with no frame in progress
        @(negedge clk);
        crs_first = 1; col = 1; col_pos = 16'd900; urun = 1; frm_done = 1;
        @(negedge clk);
        crs_first = 0; col = 0; col_pos = '0; urun = 0; frm_done = 0;
        check_all("R7 idle strobes", ed, ec, el);

        // R7: carrier sense outside the start cycle is not deferral
        @(negedge clk); frm_start = 1;
        @(negedge clk); frm_start = 0; crs_first = 1;
        @(negedge clk); crs_first = 0; frm_done = 1;
        @(negedge clk); frm_done = 0;
        check_all("R7 late crs", ed, ec, el);

        // R10: unused bits ignored on write, unmapped reads zero
        wr(8'h58, 32'hFFFF_FFFF);
        rd(8'h58, d); check("R10 deferred high bits", d, 32'h0000_FFFF);
        wr(8'h5C, 32'hABCD_12FE);
        rd(8'h5C, d); check("R10 late high bits", d, 32'h0000_00FE);
        rd(8'h00, d); check("R10 unmapped", d, 32'h0);

        // R8: saturation
        frame(1, 0, 0, 0);
        rd(8'h58, d); check("R8 deferred saturates", d, 32'h0000_FFFF);
        frame(0, 1, 16'd600, 0);
        rd(8'h5C, d); check("R8 late reaches max", d, 32'h0000_00FF);
        frame(0, 1, 16'd600, 0);
        rd(8'h5C, d); check("R8 late holds max", d, 32'h0000_00FF);
        rd(8'h60, d); check("R6 collision still counts", d, ec + 2);

        // R9: write in same cycle as increment wins
        @(negedge clk); frm_start = 1;
        @(negedge clk); frm_start = 0; col = 1; col_pos = 16'd700;
        @(negedge clk); col = 0; col_pos = '0; frm_done = 1;
        reg_addr = 8'h5C; reg_wdata = 32'h10; reg_wr = 1;
        @(negedge clk); frm_done = 0; reg_wr = 0;
        rd(8'h5C, d); check("R9 write wins", d, 32'h10);
        rd(8'h60, d); check("R9 other counter increments", d, ec + 3);

        // R1: reset clears again
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        check_all("R1 re-reset", 0, 0, 0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule